// File: doc/BRIEF.md
# Frame Timestamp Timer

This block keeps a free-running 16-bit time base for a serial bus controller and records its value whenever a frame event occurs. The count advances by one on every clock while the controller is enabled. A timestamp register copies the count on either the start-of-frame or the end-of-frame pulse, chosen by a configuration bit. Frame detection happens elsewhere; this block only receives one-cycle event pulses.

By default the counter wraps from its top value back to zero. When the freeze option is set, the counter stops at its top value and stays there until software pulses the timer clear. The three configuration bits sit in a small register with a write port. A protect input blocks all writes to that register while it is high.

Top module: `frame_timer`

## Requirements
- R1: After reset, the counter and the timestamp both read 0x0000, and all three configuration bits are 0 (controller disabled).
- R2: While the enable bit (configuration bit 0) is 1, the counter rises by exactly one on each clock edge, unless a clear or a freeze stops it.
- R3: While the enable bit is 0, the counter holds its value, and neither event pulse changes the timestamp.
- R4: With the freeze bit (configuration bit 1) at 0, a counter at 0xFFFF goes to 0x0000 on the next enabled edge.
- R5: With the freeze bit at 1, a counter at 0xFFFF stays at 0xFFFF for as long as no clear arrives.
- R6: A timer-clear pulse sets the counter to 0x0000 on the next edge. The clear overrides incrementing, works whether or not the controller is enabled, and lets a frozen counter count again.
- R7: With the edge-select bit (configuration bit 2) at 0 and the controller enabled, a start-of-frame pulse copies the counter value of that same cycle into the timestamp, which appears after the next edge. End-of-frame pulses are ignored in this setting.
- R8: With the edge-select bit at 1 and the controller enabled, an end-of-frame pulse copies the counter value of that same cycle into the timestamp. Start-of-frame pulses are ignored in this setting.
- R9: A configuration write made while the protect input is 1 leaves all three configuration bits unchanged.
- R10: An accepted configuration write takes effect from the clock edge that follows the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 3 | Configuration bits: [0] enable, [1] freeze, [2] capture on end of frame |
| cfgWrProtect | input | 1 | When 1, configuration writes are dropped |
| timerClear | input | 1 | One-cycle pulse that zeroes the counter |
| sofPulse | input | 1 | Start-of-frame event pulse |
| eofPulse | input | 1 | End-of-frame event pulse |
| timerValue | output | 16 | Current counter value |
| stampValue | output | 16 | Last captured timestamp |

## Verification
Every result of this block lands one clock edge after the stimulus that causes it. A count step, a clear or a capture shows on the outputs after the next rising edge. A configuration write needs one more edge before it affects the counter, because its bits are registered first. The bench drives inputs and samples outputs on falling edges. Its model advances one edge per call, using the configuration value from before any write in that same cycle, so each comparison lines up with the edge on which the design's result is due.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  localparam int CFG_W          = 3;
  localparam int CFG_ENABLE_BIT = 0;
  localparam int CFG_FREEZE_BIT = 1;
  localparam int CFG_EOFSEL_BIT = 2;

  typedef struct packed {
    logic inc;
    logic clr;
    logic cap;
  } timer_strobe_t;
endpackage

// File: rtl/ft_control.sv
module ft_control
  import frame_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cfgWrProtect,
  input  logic             timerClear,
  input  logic             sofPulse,
  input  logic             eofPulse,
  input  logic             atMax,
  output timer_strobe_t    strobe
);
  logic [CFG_W-1:0] cfgReg;
  logic enabled, freezeOn, eofSel, eventHit;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWrEn && !cfgWrProtect) cfgReg <= cfgWrData;
  end

  assign enabled  = cfgReg[CFG_ENABLE_BIT];
  assign freezeOn = cfgReg[CFG_FREEZE_BIT];
  assign eofSel   = cfgReg[CFG_EOFSEL_BIT];
  assign eventHit = eofSel ? eofPulse : sofPulse;

  always_comb begin
    strobe.clr = timerClear;
    strobe.inc = enabled && !timerClear && !(freezeOn && atMax);
    strobe.cap = enabled && eventHit;
  end

  // R9
  write_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrProtect) |=> $stable(cfgReg));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freezeOn && atMax) |-> !strobe.inc);

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (!strobe.inc && !strobe.cap));
endmodule

// File: rtl/ft_datapath.sv
module ft_datapath
  import frame_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  timer_strobe_t    strobe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] stamp,
  output logic             atMax
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)           count <= '0;
    else if (strobe.clr) count <= '0;
    else if (strobe.inc) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           stamp <= '0;
    else if (strobe.cap) stamp <= count;
  end

  assign atMax = (count == CNT_MAX);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (count == '0));

  // R7
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cap |=> (stamp == $past(count)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.clr) |=> $stable(count));
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import frame_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cfgWrProtect,
  input  logic             timerClear,
  input  logic             sofPulse,
  input  logic             eofPulse,
  output logic [CNT_W-1:0] timerValue,
  output logic [CNT_W-1:0] stampValue
);
  timer_strobe_t strobe;
  logic atMax;

  ft_control ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgWrProtect(cfgWrProtect), .timerClear(timerClear),
    .sofPulse(sofPulse), .eofPulse(eofPulse), .atMax(atMax), .strobe(strobe)
  );

  ft_datapath #(.CNT_W(CNT_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .count(timerValue), .stamp(stampValue), .atMax(atMax)
  );
endmodule

// File: tb/frame_timer_test.sv
module frame_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN = 1'b0, cfgWrEn = 0, cfgWrProtect = 0, timerClear = 0, sofPulse = 0, eofPulse = 0;
  logic [2:0]  cfgWrData = '0;
  logic [15:0] timerValue, stampValue;

  int checks = 0, errors = 0;
  logic [15:0] mCount = '0, mStamp = '0;
  logic [2:0]  mCfg = '0;

  frame_timer uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgWrProtect(cfgWrProtect), .timerClear(timerClear),
    .sofPulse(sofPulse), .eofPulse(eofPulse),
    .timerValue(timerValue), .stampValue(stampValue)
  );

  function automatic logic [15:0] nextCount(logic [15:0] c, logic [2:0] cfg, logic clr);
    if (clr) return 16'h0000;
    if (!cfg[0]) return c;
    if (cfg[1] && c == 16'hFFFF) return c;
    return c + 16'h1;
  endfunction

  function automatic logic [15:0] nextStamp(logic [15:0] s, logic [15:0] c, logic [2:0] cfg,
                                            logic sof, logic eof);
    if (cfg[0] && (cfg[2] ? eof : sof)) return c;
    return s;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle(string req, logic we, logic [2:0] wd, logic prot,
                       logic clr, logic sof, logic eof);
    cfgWrEn = we; cfgWrData = wd; cfgWrProtect = prot;
    timerClear = clr; sofPulse = sof; eofPulse = eof;
    mStamp = nextStamp(mStamp, mCount, mCfg, sof, eof);
    mCount = nextCount(mCount, mCfg, clr);
    if (we && !prot) mCfg = wd;
    @(negedge clk);
    check(req, "timer", timerValue, mCount);
    check(req, "stamp", stampValue, mStamp);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) cycle(req, 0, 3'b000, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R1", "timer in reset", timerValue, 16'h0000);
    check("R1", "stamp in reset", stampValue, 16'h0000);
    rstN = 1'b1;
    idle("R1", 3);
    // R3: disabled, events do nothing
    cycle("R3", 0, 0, 0, 0, 1, 0);
    cycle("R3", 0, 0, 0, 0, 0, 1);
    // R9: protected write dropped
    cycle("R9", 1, 3'b001, 1, 0, 0, 0);
    idle("R9", 3);
    // R10: write lands, counting starts one edge later
    cycle("R10", 1, 3'b001, 0, 0, 0, 0);
    idle("R10", 1);
    idle("R2", 5);
    // R7: SOF capture, EOF ignored
    cycle("R7", 0, 0, 0, 0, 1, 0);
    idle("R7", 2);
    cycle("R7", 0, 0, 0, 0, 0, 1);
    // R8: switch to EOF capture
    cycle("R8", 1, 3'b101, 0, 0, 0, 0);
    cycle("R8", 0, 0, 0, 0, 1, 0);
    cycle("R8", 0, 0, 0, 0, 0, 1);
    idle("R8", 2);
    // R6: clear wins over increment; capture sees pre-clear value
    cycle("R6", 0, 0, 0, 1, 0, 1);
    idle("R6", 3);
    // R3: disable, then events and a clear while disabled
    cycle("R3", 1, 3'b100, 0, 0, 0, 0);
    cycle("R3", 0, 0, 0, 0, 1, 1);
    idle("R3", 3);
    cycle("R6", 0, 0, 0, 1, 0, 0);
    idle("R6", 2);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we, prot, clr, sof, eof;
      logic [2:0] wd;
      we = ($urandom % 10) == 0;  prot = $urandom % 2;
      clr = ($urandom % 25) == 0; sof = ($urandom % 6) == 0;
      eof = ($urandom % 6) == 0;  wd = 3'($urandom);
      cycle("R2", we, wd, prot, clr, sof, eof);
    end
    // R4: wrap with freeze off
    cycle("R4", 1, 3'b001, 0, 1, 0, 0);
    idle("R4", 65540);
    // R5: saturate with freeze on
    cycle("R5", 1, 3'b011, 0, 1, 0, 0);
    idle("R5", 65540);
    check("R5", "frozen value", timerValue, 16'hFFFF);
    cycle("R5", 0, 0, 0, 0, 1, 0);
    // R6: clear restarts a frozen counter
    cycle("R6", 0, 0, 0, 1, 0, 0);
    idle("R6", 4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule